// File: doc/BRIEF.md
# Cascadable Segment Column Data Loader

This block is the logic core of an 80-column segment driver for a passive display. Each line of display data is shifted into an 80-bit register, one bit per shift strobe in serial mode or four bits per strobe in nibble mode. The shift direction can be reversed so that a board can mount the part either way up. A falling edge on the line strobe copies the register into an 80-bit output latch. Each column then gets a 2-bit drive-level code, chosen from its latched bit, the frame-alternation input and an active-low blanking input. The level shifting and high-voltage stages that act on these codes are outside this block.

Several loaders can sit on one shared data bus in a chain. Each device has an enable pin on each side. The pin on the input side tells the device it may take data. The pin on the output side hands that right on to the next device once this one holds a full line. A high level on the line strobe clears the hand-off, ready for the next line. Both strobes are sampled by the system clock and their edges are found synchronously. The data pins carry no valid/ready handshake and there is no back-pressure: a strobe that the device refuses is simply lost.

Top module: `seg_col_loader`

## Requirements
- R1: With `mode_serial`=0, each accepted shift strobe loads all four bits `din[3:0]`. With `dir_rev`=0, `din[j]` enters column j+1 (index j) and earlier groups move four places toward column 80.
- R2: With `mode_serial`=1, each accepted strobe loads only `din[0]`. The levels on `din[3:1]` have no effect on the latched data.
- R3: The output-role enable pin is high until the strobe that completes the line is accepted, and low after it. A line is 80 strobes in serial mode and 20 in nibble mode. Strobes after that point leave the register unchanged.
- R4: With `dir_rev`=0, data enters at column 1 and moves toward column 80, so the first serial bit ends in column 80. With `dir_rev`=1 the movement is mirrored: data enters at column 80, the first bit ends in column 1, and in nibble mode `din[j]` enters column 80-j.
- R5: With `dir_rev`=0, `en_right_i` is the enable input and `en_left_o` is the token output, and `en_right_o` stays high. With `dir_rev`=1 the roles swap and `en_left_o` stays high.
- R6: A shift strobe is ignored while the enable-input pin is high or while `latch_clk` is high.
- R7: While `latch_clk` is high, the line count and the full state clear. From the next cycle the token-output pin is high.
- R8: A falling edge of `latch_clk` copies the register into the output latch. At all other times the latch, and so `lvl_o`, keeps its data.
- R9: The code for column c is `lvl_o[2c+1:2c]`, with column 1 at c=0. The codes are V0=00, V12=01, V43=10 and V5=11. With `frame`=0, a latched 0 gives V12 and a latched 1 gives V0. With `frame`=1, a latched 0 gives V43 and a latched 1 gives V5.
- R10: While `disp_off_n` is low, every column code is V0 (00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_serial | input | 1 | 1 = one bit per strobe, 0 = four bits per strobe |
| dir_rev | input | 1 | Shift direction and role of the enable pins |
| shift_clk | input | 1 | Shift strobe; acts on its rising edge |
| latch_clk | input | 1 | Line strobe; high level clears, falling edge latches |
| din | input | 4 | Display data (only bit 0 in serial mode) |
| en_left_i | input | 1 | Left enable pin, input side |
| en_right_i | input | 1 | Right enable pin, input side |
| en_left_o | output | 1 | Left enable pin, output side |
| en_right_o | output | 1 | Right enable pin, output side |
| frame | input | 1 | Frame-alternation signal |
| disp_off_n | input | 1 | Active-low blanking |
| lvl_o | output | 160 | Two-bit drive code per column |

## Verification
Each of the four mode and direction pairs loads a line of several column patterns: alternating bits, a pseudo-random mix, two isolated ones and every third column set. A fault that drops columns, swaps bits inside a nibble or reverses the direction gives a different latched picture for at least one of these patterns. Serial loads drive junk on `din[3:1]` to expose any leak from the unused pins. Every load ends with one extra strobe of contrasting data and the token pin is read one strobe before and at the end of the line, which pins down the 20- and 80-strobe counts. Strobes sent with the enable input high or with the line strobe held high must leave the previous picture intact. A frame and blanking sweep over a known latch checks every code.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;

  typedef enum logic [1:0] {
    LVL_V0  = 2'b00,
    LVL_V12 = 2'b01,
    LVL_V43 = 2'b10,
    LVL_V5  = 2'b11
  } drive_lvl_e;

  // Map one latched column bit to its drive level.
  function automatic drive_lvl_e drive_code(input logic frame, input logic bit_val,
                                            input logic disp_on);
    drive_lvl_e r;
    if (!disp_on)     r = LVL_V0;
    else if (!frame)  r = bit_val ? LVL_V0 : LVL_V12;
    else              r = bit_val ? LVL_V5 : LVL_V43;
    return r;
  endfunction

endpackage

// File: rtl/seg_clk_edges.sv
module seg_clk_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_clk,
  input  logic latch_clk,
  output logic shift_rise,
  output logic latch_fall
);
  logic sh_q, lt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= 1'b0;
      lt_q <= 1'b0;
    end else begin
      sh_q <= shift_clk;
      lt_q <= latch_clk;
    end
  end

  assign shift_rise = shift_clk & ~sh_q;
  assign latch_fall = ~latch_clk & lt_q;
endmodule

// File: rtl/seg_shift_array.sv
module seg_shift_array #(
  parameter int COLS = 80,
  parameter int NIB  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            mode_serial,
  input  logic            dir_rev,
  input  logic [NIB-1:0]  din,
  output logic [COLS-1:0] sr_q
);
  logic [COLS-1:0] nxt;

  // Each column selects among four neighbours: serial or nibble step, either direction.
  for (genvar i = 0; i < COLS; i++) begin : g_col
    logic fwd_ser, fwd_nib, rev_ser, rev_nib;
    if (i == 0) begin : g_fs0
      assign fwd_ser = din[0];
    end else begin : g_fs
      assign fwd_ser = sr_q[i-1];
    end
    if (i < NIB) begin : g_fn0
      assign fwd_nib = din[i];
    end else begin : g_fn
      assign fwd_nib = sr_q[i-NIB];
    end
    if (i == COLS-1) begin : g_rs0
      assign rev_ser = din[0];
    end else begin : g_rs
      assign rev_ser = sr_q[i+1];
    end
    if (i >= COLS-NIB) begin : g_rn0
      assign rev_nib = din[COLS-1-i];
    end else begin : g_rn
      assign rev_nib = sr_q[i+NIB];
    end
    assign nxt[i] = dir_rev ? (mode_serial ? rev_ser : rev_nib)
                            : (mode_serial ? fwd_ser : fwd_nib);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sr_q <= '0;
    else if (load) sr_q <= nxt;
  end
endmodule

// File: rtl/seg_token_ctrl.sv
module seg_token_ctrl #(
  parameter int COLS = 80,
  parameter int NIB  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic reinit,
  input  logic mode_serial,
  output logic full_q
);
  localparam int CW = $clog2(COLS + 1);
  localparam logic [CW-1:0] SER_LEN = CW'(COLS);
  localparam logic [CW-1:0] NIB_LEN = CW'(COLS / NIB);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] need;

  assign need = mode_serial ? SER_LEN : NIB_LEN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (reinit) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (accept) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q + 1'b1 >= need) full_q <= 1'b1;
    end
  end
endmodule

// File: rtl/seg_level_enc.sv
module seg_level_enc
  import seg_loader_pkg::*;
#(
  parameter int COLS = 80
) (
  input  logic [COLS-1:0]   lat,
  input  logic              frame,
  input  logic              disp_off_n,
  output logic [2*COLS-1:0] lvl_o
);
  for (genvar i = 0; i < COLS; i++) begin : g_enc
    assign lvl_o[2*i +: 2] = drive_code(frame, lat[i], disp_off_n);
  end
endmodule

// File: rtl/seg_col_loader.sv
module seg_col_loader #(
  parameter int COLS = 80,
  parameter int NIB  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_serial,
  input  logic              dir_rev,
  input  logic              shift_clk,
  input  logic              latch_clk,
  input  logic [NIB-1:0]    din,
  input  logic              en_left_i,
  input  logic              en_right_i,
  output logic              en_left_o,
  output logic              en_right_o,
  input  logic              frame,
  input  logic              disp_off_n,
  output logic [2*COLS-1:0] lvl_o
);
  logic            shift_rise, latch_fall;
  logic            en_in, accept, full_q;
  logic [COLS-1:0] sr_q, lat_q;

  seg_clk_edges u_edges (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_clk  (shift_clk),
    .latch_clk  (latch_clk),
    .shift_rise (shift_rise),
    .latch_fall (latch_fall)
  );

  assign en_in  = dir_rev ? en_left_i : en_right_i;
  assign accept = shift_rise & ~en_in & ~latch_clk & ~full_q;

  seg_token_ctrl #(.COLS(COLS), .NIB(NIB)) u_tok (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .reinit      (latch_clk),
    .mode_serial (mode_serial),
    .full_q      (full_q)
  );

  seg_shift_array #(.COLS(COLS), .NIB(NIB)) u_sr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .mode_serial (mode_serial),
    .dir_rev     (dir_rev),
    .din         (din),
    .sr_q        (sr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lat_q <= '0;
    else if (latch_fall) lat_q <= sr_q;
  end

  // Token goes out on the side away from the input; the idle pin rests high.
  assign en_left_o  = dir_rev ? 1'b1 : ~full_q;
  assign en_right_o = dir_rev ? ~full_q : 1'b1;

  seg_level_enc #(.COLS(COLS)) u_enc (
    .lat        (lat_q),
    .frame      (frame),
    .disp_off_n (disp_off_n),
    .lvl_o      (lvl_o)
  );
endmodule

// File: rtl/seg_col_loader_chk.sv
module seg_col_loader_chk #(
  parameter int COLS = 80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir_rev,
  input logic              latch_clk,
  input logic              en_left_i,
  input logic              en_right_i,
  input logic              en_left_o,
  input logic              en_right_o,
  input logic              disp_off_n,
  input logic [2*COLS-1:0] lvl_o,
  input logic [COLS-1:0]   sr,
  input logic [COLS-1:0]   lat
);
  AST_BLANK_ALL_V0: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_off_n |-> (lvl_o == '0)); // R10

  AST_IDLE_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rev ? en_left_o : en_right_o) == 1'b1); // R5

  AST_TOKEN_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clk |=> (dir_rev ? en_right_o : en_left_o)); // R7

  AST_GATED_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_rev ? en_left_i : en_right_i) || latch_clk) |=> $stable(sr)); // R6

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(latch_clk) && !latch_clk) |=> $stable(lat)); // R8
endmodule

bind seg_col_loader seg_col_loader_chk #(.COLS(COLS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dir_rev    (dir_rev),
  .latch_clk  (latch_clk),
  .en_left_i  (en_left_i),
  .en_right_i (en_right_i),
  .en_left_o  (en_left_o),
  .en_right_o (en_right_o),
  .disp_off_n (disp_off_n),
  .lvl_o      (lvl_o),
  .sr         (sr_q),
  .lat        (lat_q)
);

// File: tb/seg_col_loader_tb.sv
`timescale 1ns/1ps
module seg_col_loader_tb;
  localparam int COLS = 80;
  localparam int NIB  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_serial = 1'b0, dir_rev = 1'b0, shift_clk = 1'b0, latch_clk = 1'b0;
  logic [NIB-1:0] din = '0;
  logic en_left_i = 1'b0, en_right_i = 1'b0;
  logic en_left_o, en_right_o;
  logic frame = 1'b1, disp_off_n = 1'b1;
  logic [2*COLS-1:0] lvl_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [COLS-1:0] exp_lat = '0;

  always #4 clk = ~clk;

  seg_col_loader #(.COLS(COLS), .NIB(NIB)) u_dut (.*);

  function automatic logic [2*COLS-1:0] exp_lvl(input logic [COLS-1:0] v, input logic f,
                                                input logic on);
    logic [2*COLS-1:0] r;
    for (int c = 0; c < COLS; c++) r[2*c +: 2] = on ? {f, ~(f ^ v[c])} : 2'b00;
    return r;
  endfunction

  function automatic logic pat(input int c, input int p);
    case (p)
      0:       return logic'(c % 2);
      1:       return logic'(((c * 5 + 3) % 7) < 3);
      2:       return logic'(c == 17 || c == 62);
      default: return logic'(c % 3 == 0);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [2*COLS-1:0] act,
                     input logic [2*COLS-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [NIB-1:0] d);
    @(negedge clk); din = d; shift_clk = 1'b1;
    repeat (2) @(negedge clk);
    shift_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic latch_pulse();
    @(negedge clk); latch_clk = 1'b1;
    repeat (2) @(negedge clk);
    latch_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic tok_pin();
    return dir_rev ? en_right_o : en_left_o;
  endfunction

  // Load one full line of pattern p, checking token timing, then latch and compare.
  task automatic load_line(input logic ser, input logic rev, input int p);
    logic [COLS-1:0] want;
    int n;
    mode_serial = ser; dir_rev = rev;
    latch_pulse();
    chk(tok_pin() == 1'b1, "R7 token high after line strobe", {159'd0, tok_pin()}, 160'd1);
    n = ser ? COLS : COLS / NIB;
    for (int c = 0; c < COLS; c++) want[c] = pat(c, p);
    for (int k = 0; k < n; k++) begin
      logic [NIB-1:0] d;
      if (ser) d = {3'b101 ^ NIB'(k), rev ? want[k] : want[COLS-1-k]};
      else for (int j = 0; j < NIB; j++)
        d[j] = rev ? want[NIB*k + NIB-1-j] : want[NIB*(COLS/NIB-1-k) + j];
      if (k == n - 1)
        chk(tok_pin() == 1'b1, "R3 token high one strobe before end", {159'd0, tok_pin()}, 160'd1);
      strobe(d);
    end
    chk(tok_pin() == 1'b0, "R3 token low at line end", {159'd0, tok_pin()}, 160'd0);
    chk((rev ? en_left_o : en_right_o) == 1'b1, "R5 idle enable pin high",
        {158'd0, en_left_o, en_right_o}, 160'd0);
    strobe(~din);  // must be refused (R3)
    // Hold the line strobe high: latched data must not change yet (R8).
    @(negedge clk); latch_clk = 1'b1;
    repeat (2) @(negedge clk);
    chk(lvl_o === exp_lvl(exp_lat, frame, 1'b1), "R8 latch holds while strobe high",
        lvl_o, exp_lvl(exp_lat, frame, 1'b1));
    latch_clk = 1'b0;
    repeat (3) @(negedge clk);
    exp_lat = want;
    chk(lvl_o === exp_lvl(want, 1'b1, 1'b1),
        ser ? (rev ? "R2 R4 serial reversed load" : "R2 R4 serial forward load")
            : (rev ? "R1 R4 nibble reversed load" : "R1 R4 nibble forward load"),
        lvl_o, exp_lvl(want, 1'b1, 1'b1));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    frame = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lvl_o === exp_lvl('0, 1'b0, 1'b1), "R9 reset state all V12", lvl_o, exp_lvl('0, 1'b0, 1'b1));
    frame = 1'b1;

    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 4; p++)
        load_line(logic'(m[1]), logic'(m[0]), p);

    // R6: strobes with the enable input high are refused.
    mode_serial = 1'b1; dir_rev = 1'b0;
    latch_pulse();
    en_right_i = 1'b1;
    for (int k = 0; k < 8; k++) strobe(4'hF);
    en_right_i = 1'b0;
    latch_pulse();
    chk(lvl_o === exp_lvl(exp_lat, 1'b1, 1'b1), "R6 enable input high ignores strobes",
        lvl_o, exp_lvl(exp_lat, 1'b1, 1'b1));

    dir_rev = 1'b1;
    latch_pulse();
    en_left_i = 1'b1;
    for (int k = 0; k < 8; k++) strobe(4'h0);
    en_left_i = 1'b0;
    latch_pulse();
    chk(lvl_o === exp_lvl(exp_lat, 1'b1, 1'b1), "R6 R5 left pin is input when reversed",
        lvl_o, exp_lvl(exp_lat, 1'b1, 1'b1));

    // R6: strobes during a high line strobe are refused.
    @(negedge clk); latch_clk = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); din = 4'hF; shift_clk = 1'b1;
      @(negedge clk); shift_clk = 1'b0;
    end
    latch_clk = 1'b0;
    repeat (3) @(negedge clk);
    chk(lvl_o === exp_lvl(exp_lat, 1'b1, 1'b1), "R6 line strobe high ignores strobes",
        lvl_o, exp_lvl(exp_lat, 1'b1, 1'b1));

    // R9 / R10 sweep over frame and blanking.
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); frame = logic'(s[0]); disp_off_n = logic'(s[1]);
      @(negedge clk);
      chk(lvl_o === exp_lvl(exp_lat, frame, disp_off_n),
          disp_off_n ? "R9 level code table" : "R10 blanking forces V0",
          lvl_o, exp_lvl(exp_lat, frame, disp_off_n));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule